// File: doc/BRIEF.md
# Indexed error record access window

This block holds a small bank of 64-bit feature words, one per error record, and a selector register that names one record. A system register read port, addressed by a coprocessor-style encoding, shows software a 32-bit alias of the selected record. The alias always carries the upper half of the record's feature word. The selector is loaded through its own write port. The record contents are loaded through a separate record write port.

Permission and trap evaluation is not part of this block. The surrounding logic supplies an allow signal with each access. The block classifies every access request as one of four outcomes: a data read, an undefined access, a request that does not decode, or an out-of-range read. The result shows up on registered outputs one cycle after the request.

When the selector points past the last implemented record, the read completes and returns zero. A block built with no records at all behaves the same way for every read. A flag marks this fallback case.

Top module: `err_rec_window`

## Requirements
- R1: An access request decodes only when coprocessor = 4'b1111, opc1 = 3'b000, CRn = 4'b0101, CRm = 4'b0100 and opc2 = 3'b100. Its result is presented on the clock edge after the request cycle.
- R2: A decoded, allowed request with selector value s below the record count sets rd_valid = 1 and rd_fallback = 0, and returns bits 63:32 of record s on rd_data.
- R3: A decoded, allowed request with a selector value at or above the record count sets rd_valid = 1 and rd_fallback = 1, with rd_data = 0.
- R4: With a record count of zero, every decoded, allowed request is a fallback read returning zero.
- R5: A decoded request with allow = 0 sets rd_undef = 1 and rd_valid = 0, and leaves rd_data at its previous value.
- R6: When the block is built without the error-reporting feature (FEAT_PRESENT = 0), every decoded request gives rd_undef = 1 and never rd_valid.
- R7: A request whose encoding differs in any field sets rd_nodec = 1, with rd_valid = 0 and rd_undef = 0, and leaves rd_data unchanged. At most one of rd_valid, rd_undef and rd_nodec is ever 1.
- R8: A cycle with no request gives rd_valid = rd_undef = rd_nodec = rd_fallback = 0 on the next edge, and rd_data is held.
- R9: Synchronous reset clears the selector to 0, rd_data to 0 and all result flags to 0.
- R10: A selector write in the same cycle as a request does not affect that request, which reads with the old selector value. The next request uses the new value.
- R11: A record write in the same cycle as a read of that record returns the old content. The following read returns the new content.
- R12: The selector is compared against the record count at its full 16-bit width. Values such as 0x0108 or 0x8000 are out of range and are not folded onto a low index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Selector write enable |
| sel_wdata | input | SEL_W | New selector value |
| rec_we | input | 1 | Record write enable |
| rec_widx | input | IDX_W | Record index to write |
| rec_wdata | input | REC_W | Feature word to store |
| acc_req | input | 1 | Access request strobe |
| acc_cp | input | 4 | Coprocessor number of the access |
| acc_op1 | input | 3 | opc1 field |
| acc_crn | input | 4 | CRn field |
| acc_crm | input | 4 | CRm field |
| acc_op2 | input | 3 | opc2 field |
| acc_allow | input | 1 | Access permitted by external trap logic |
| rd_valid | output | 1 | Registered: read completed with data |
| rd_undef | output | 1 | Registered: access is undefined |
| rd_nodec | output | 1 | Registered: encoding not decoded |
| rd_fallback | output | 1 | Registered: selector out of range, zero returned |
| rd_data | output | WIN_W | Registered alias read data |

## Verification
A selector write and an access request can share a cycle. A record write and a read of that same record can also share a cycle. The bench provokes both on purpose: during the main read loop every access carries a write of the next selector value, and one read of record 5 lands in the cycle that rewrites record 5. The scoreboard predicts the old selector and the old record content for those cycles, and the new ones for the access that follows. A copy with write-first or bypass behaviour therefore shows up as a data mismatch.

// File: rtl/err_win_pkg.sv
package err_win_pkg;

  typedef struct packed {
    logic [3:0] cp;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } acc_enc_t;

  localparam acc_enc_t WIN_ENC = '{cp: 4'hF, op1: 3'h0, crn: 4'h5, crm: 4'h4, op2: 3'h4};

  typedef enum logic [1:0] {
    RES_IDLE  = 2'd0,
    RES_DATA  = 2'd1,
    RES_UNDEF = 2'd2,
    RES_NODEC = 2'd3
  } res_kind_t;

endpackage

// File: rtl/err_win_decode.sv
module err_win_decode
  import err_win_pkg::*;
#(
  parameter int FEAT_PRESENT = 1
) (
  input  logic      req,
  input  acc_enc_t  enc,
  input  logic      allow,
  output res_kind_t kind
);

  always_comb begin
    kind = RES_IDLE;
    if (req) begin
      if (enc != WIN_ENC) begin
        kind = RES_NODEC;
      end else if ((FEAT_PRESENT == 0) || !allow) begin
        kind = RES_UNDEF;
      end else begin
        kind = RES_DATA;
      end
    end
  end

endmodule

// File: rtl/err_win_select.sv
module err_win_select #(
  parameter int NUM_REC = 8,
  parameter int SEL_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wdata,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (we) begin
      sel_q <= wdata;
    end
  end

  assign idx = sel_q[IDX_W-1:0];

  generate
    if (NUM_REC == 0) begin : g_empty
      assign in_range = 1'b0;
    end else begin : g_cmp
      assign in_range = (32'(sel_q) < 32'(NUM_REC));
    end
  endgenerate

endmodule

// File: rtl/err_win_store.sv
module err_win_store #(
  parameter int NUM_REC = 8,
  parameter int REC_W   = 64,
  parameter int WIN_W   = 32,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [REC_W-1:0] wdata,
  input  logic             ld,
  input  logic             clr,
  input  logic [IDX_W-1:0] ridx,
  output logic [WIN_W-1:0] rdata
);

  localparam int WIN_LSB = REC_W - WIN_W;

  generate
    if (NUM_REC == 0) begin : g_none
      always_ff @(posedge clk) begin
        if (rst || ld) begin
          rdata <= '0;
        end
      end
    end else begin : g_mem
      logic [REC_W-1:0] mem [NUM_REC];

      always_ff @(posedge clk) begin
        if (we && (32'(widx) < 32'(NUM_REC))) begin
          mem[widx] <= wdata;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          rdata <= '0;
        end else if (ld) begin
          if (clr) begin
            rdata <= '0;
          end else begin
            rdata <= mem[ridx][WIN_LSB +: WIN_W];
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/err_rec_window.sv
module err_rec_window
  import err_win_pkg::*;
#(
  parameter int NUM_REC      = 8,
  parameter int SEL_W        = 16,
  parameter int REC_W        = 64,
  parameter int WIN_W        = 32,
  parameter int FEAT_PRESENT = 1,
  localparam int IDX_W       = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             rec_we,
  input  logic [IDX_W-1:0] rec_widx,
  input  logic [REC_W-1:0] rec_wdata,
  input  logic             acc_req,
  input  logic [3:0]       acc_cp,
  input  logic [2:0]       acc_op1,
  input  logic [3:0]       acc_crn,
  input  logic [3:0]       acc_crm,
  input  logic [2:0]       acc_op2,
  input  logic             acc_allow,
  output logic             rd_valid,
  output logic             rd_undef,
  output logic             rd_nodec,
  output logic             rd_fallback,
  output logic [WIN_W-1:0] rd_data
);

  acc_enc_t         enc;
  res_kind_t        kind;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_in_range;
  logic             load;
  logic             valid_q, undef_q, nodec_q, fb_q;

  assign enc = '{cp: acc_cp, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

  err_win_decode #(.FEAT_PRESENT(FEAT_PRESENT)) u_decode (
    .req   (acc_req),
    .enc   (enc),
    .allow (acc_allow),
    .kind  (kind)
  );

  err_win_select #(.NUM_REC(NUM_REC), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_select (
    .clk      (clk),
    .rst      (rst),
    .we       (sel_we),
    .wdata    (sel_wdata),
    .idx      (cur_idx),
    .in_range (cur_in_range)
  );

  assign load = (kind == RES_DATA);

  err_win_store #(.NUM_REC(NUM_REC), .REC_W(REC_W), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (rec_we),
    .widx  (rec_widx),
    .wdata (rec_wdata),
    .ld    (load),
    .clr   (!cur_in_range),
    .ridx  (cur_idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      nodec_q <= 1'b0;
      fb_q    <= 1'b0;
    end else begin
      valid_q <= load;
      undef_q <= (kind == RES_UNDEF);
      nodec_q <= (kind == RES_NODEC);
      fb_q    <= load && !cur_in_range;
    end
  end

  assign rd_valid    = valid_q;
  assign rd_undef    = undef_q;
  assign rd_nodec    = nodec_q;
  assign rd_fallback = fb_q;

endmodule

// File: rtl/err_rec_window_chk.sv
module err_rec_window_chk
  import err_win_pkg::*;
#(
  parameter int FEAT_PRESENT = 1,
  parameter int WIN_W        = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_req,
  input logic [3:0]       acc_cp,
  input logic [2:0]       acc_op1,
  input logic [3:0]       acc_crn,
  input logic [3:0]       acc_crm,
  input logic [2:0]       acc_op2,
  input logic             acc_allow,
  input logic             rd_valid,
  input logic             rd_undef,
  input logic             rd_nodec,
  input logic             rd_fallback,
  input logic [WIN_W-1:0] rd_data
);

  logic hit;
  assign hit = ({acc_cp, acc_op1, acc_crn, acc_crm, acc_op2} == WIN_ENC);

  p_one_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, rd_undef, rd_nodec}));

  p_decoded_read_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_req && hit && acc_allow && (FEAT_PRESENT != 0)) |=> rd_valid);

  p_deny_undef_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_req && hit && !acc_allow) |=> (rd_undef && !rd_valid && $stable(rd_data)));

  p_nodec_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !hit) |=> (rd_nodec && $stable(rd_data)));

  p_fallback_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_fallback |-> (rd_valid && (rd_data == '0)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_req |=> (!rd_valid && !rd_undef && !rd_nodec && !rd_fallback && $stable(rd_data)));

  p_absent_undef_r6: assert property (@(posedge clk) disable iff (rst)
    ((FEAT_PRESENT == 0) && acc_req && hit) |=> (rd_undef && !rd_valid));

endmodule

bind err_rec_window err_rec_window_chk #(.FEAT_PRESENT(FEAT_PRESENT), .WIN_W(WIN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_req     (acc_req),
  .acc_cp      (acc_cp),
  .acc_op1     (acc_op1),
  .acc_crn     (acc_crn),
  .acc_crm     (acc_crm),
  .acc_op2     (acc_op2),
  .acc_allow   (acc_allow),
  .rd_valid    (rd_valid),
  .rd_undef    (rd_undef),
  .rd_nodec    (rd_nodec),
  .rd_fallback (rd_fallback),
  .rd_data     (rd_data)
);

// File: tb/test_err_rec_window.sv
`timescale 1ns/1ps
module test_err_rec_window;

  typedef struct {
    logic        v, u, n, f;
    logic [31:0] d;
  } res_t;

  typedef struct {
    res_t  a, z, x;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_we = 1'b0;
  logic [15:0] sel_wdata = '0;
  logic        rec_we = 1'b0;
  logic [2:0]  rec_widx = '0;
  logic [63:0] rec_wdata = '0;
  logic        acc_req = 1'b0;
  logic [3:0]  acc_cp = '0;
  logic [2:0]  acc_op1 = '0;
  logic [3:0]  acc_crn = '0;
  logic [3:0]  acc_crm = '0;
  logic [2:0]  acc_op2 = '0;
  logic        acc_allow = 1'b0;

  logic a_v, a_u, a_n, a_f; logic [31:0] a_d;
  logic z_v, z_u, z_n, z_f; logic [31:0] z_d;
  logic x_v, x_u, x_n, x_f; logic [31:0] x_d;

  always #2.5 clk = ~clk;

  err_rec_window i_err_rec_window (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .rec_we(rec_we), .rec_widx(rec_widx), .rec_wdata(rec_wdata),
    .acc_req(acc_req), .acc_cp(acc_cp), .acc_op1(acc_op1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_allow(acc_allow),
    .rd_valid(a_v), .rd_undef(a_u), .rd_nodec(a_n), .rd_fallback(a_f), .rd_data(a_d));

  err_rec_window #(.NUM_REC(0)) i_err_rec_window_empty (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .rec_we(1'b0), .rec_widx(1'b0), .rec_wdata(rec_wdata),
    .acc_req(acc_req), .acc_cp(acc_cp), .acc_op1(acc_op1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_allow(acc_allow),
    .rd_valid(z_v), .rd_undef(z_u), .rd_nodec(z_n), .rd_fallback(z_f), .rd_data(z_d));

  err_rec_window #(.FEAT_PRESENT(0)) i_err_rec_window_absent (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .rec_we(rec_we), .rec_widx(rec_widx), .rec_wdata(rec_wdata),
    .acc_req(acc_req), .acc_cp(acc_cp), .acc_op1(acc_op1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_allow(acc_allow),
    .rd_valid(x_v), .rd_undef(x_u), .rd_nodec(x_n), .rd_fallback(x_f), .rd_data(x_d));

  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  item_t       sb[$];
  logic [31:0] mem_hi [8];
  int          sel_m = 0;
  logic [31:0] held_a = '0;

  function automatic res_t predict(int nrec, bit feat, bit req, bit match, bit allow,
                                   int sel, logic [31:0] hi, logic [31:0] held);
    res_t r;
    r.v = 1'b0; r.u = 1'b0; r.n = 1'b0; r.f = 1'b0; r.d = held;
    if (req) begin
      if (!match) r.n = 1'b1;
      else if (!feat || !allow) r.u = 1'b1;
      else begin
        r.v = 1'b1;
        if (sel >= nrec) begin r.f = 1'b1; r.d = '0; end
        else r.d = hi;
      end
    end
    return r;
  endfunction

  task automatic check(string who, string tag, res_t e, logic v, logic u, logic n, logic f, logic [31:0] d);
    checks++;
    if ({v, u, n, f} !== {e.v, e.u, e.n, e.f} || d !== e.d) begin
      errors++;
      $display("FAIL %s %s: actual v=%b u=%b n=%b f=%b d=%h expected v=%b u=%b n=%b f=%b d=%h",
               tag, who, v, u, n, f, d, e.v, e.u, e.n, e.f, e.d);
    end
  endtask

  task automatic cyc(bit req, logic [3:0] cp, logic [2:0] o1, logic [3:0] crn, logic [3:0] crm,
                     logic [2:0] o2, bit allow, bit swe, int swd, bit rwe, int ridx,
                     logic [63:0] rwd, string tag);
    item_t it;
    bit    match;
    logic [31:0] hi;
    @(negedge clk);
    acc_req = req; acc_cp = cp; acc_op1 = o1; acc_crn = crn; acc_crm = crm; acc_op2 = o2;
    acc_allow = allow; sel_we = swe; sel_wdata = 16'(swd);
    rec_we = rwe; rec_widx = 3'(ridx); rec_wdata = rwd;
    match = (cp == 4'hF) && (o1 == 3'h0) && (crn == 4'h5) && (crm == 4'h4) && (o2 == 3'h4);
    hi = (sel_m < 8) ? mem_hi[sel_m] : '0;
    it.a = predict(8, 1'b1, req, match, allow, sel_m, hi, held_a);
    it.z = predict(0, 1'b1, req, match, allow, sel_m, '0, '0);
    it.x = predict(8, 1'b0, req, match, allow, sel_m, '0, '0);
    it.tag = tag;
    sb.push_back(it);
    held_a = it.a.d;
    if (swe) sel_m = swd & 16'hFFFF;
    if (rwe) mem_hi[ridx] = rwd[63:32];
  endtask

  task automatic rd(bit allow, string tag);
    cyc(1'b1, 4'hF, 3'h0, 4'h5, 4'h4, 3'h4, allow, 1'b0, 0, 1'b0, 0, '0, tag);
  endtask

  task automatic setsel(int s);
    cyc(1'b0, 4'h0, 3'h0, 4'h0, 4'h0, 3'h0, 1'b0, 1'b1, s, 1'b0, 0, '0, "R8");
  endtask

  // Monitor: results appear one edge after the request cycle (R1).
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check("main",   it.tag, it.a, a_v, a_u, a_n, a_f, a_d);
        check("empty",  "R4",   it.z, z_v, z_u, z_n, z_f, z_d);
        check("absent", "R6",   it.x, x_v, x_u, x_n, x_f, x_d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    res_t zero;
    zero.v = 0; zero.u = 0; zero.n = 0; zero.f = 0; zero.d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state on all builds
    check("main",   "R9", zero, a_v, a_u, a_n, a_f, a_d);
    check("empty",  "R9", zero, z_v, z_u, z_n, z_f, z_d);
    check("absent", "R9", zero, x_v, x_u, x_n, x_f, x_d);
    rst = 1'b0;

    // Load records while idle (R8 idle checks)
    for (int i = 0; i < 8; i++)
      cyc(1'b0, 4'h0, 3'h0, 4'h0, 4'h0, 3'h0, 1'b0, 1'b0, 0, 1'b1, i,
          {32'h1000_0000 + 32'(i) * 32'h0101_0101, 32'hC0DE_0000 + 32'(i)}, "R8");

    rd(1'b1, "R9_sel_reset_R2");
    // R10: selector write lands in the same cycle as the read
    for (int s = 1; s < 8; s++)
      cyc(1'b1, 4'hF, 3'h0, 4'h5, 4'h4, 3'h4, 1'b1, 1'b1, s, 1'b0, 0, '0, "R10");
    rd(1'b1, "R2");
    setsel(2);
    rd(1'b1, "R1_R2");

    // R7: each field off by one
    cyc(1'b1, 4'hE, 3'h0, 4'h5, 4'h4, 3'h4, 1'b1, 1'b0, 0, 1'b0, 0, '0, "R7");
    cyc(1'b1, 4'hF, 3'h1, 4'h5, 4'h4, 3'h4, 1'b1, 1'b0, 0, 1'b0, 0, '0, "R7");
    cyc(1'b1, 4'hF, 3'h0, 4'h4, 4'h4, 3'h4, 1'b1, 1'b0, 0, 1'b0, 0, '0, "R7");
    cyc(1'b1, 4'hF, 3'h0, 4'h5, 4'h5, 3'h4, 1'b1, 1'b0, 0, 1'b0, 0, '0, "R7");
    cyc(1'b1, 4'hF, 3'h0, 4'h5, 4'h4, 3'h5, 1'b1, 1'b0, 0, 1'b0, 0, '0, "R7");

    // R5: denied access
    rd(1'b0, "R5");
    rd(1'b0, "R5");

    // R3 / R12: out-of-range selectors
    setsel(8);      rd(1'b1, "R3");
    setsel(3);      rd(1'b1, "R2");
    setsel(16'h0108); rd(1'b1, "R12");
    setsel(4);      rd(1'b1, "R2");
    setsel(16'h8000); rd(1'b1, "R12");
    setsel(16'hFFFF); rd(1'b1, "R3");
    rd(1'b0, "R5");

    // R8: idle holds data
    setsel(6); rd(1'b1, "R2");
    cyc(1'b0, 4'hF, 3'h0, 4'h5, 4'h4, 3'h4, 1'b1, 1'b0, 0, 1'b0, 0, '0, "R8");
    cyc(1'b0, 4'h0, 3'h0, 4'h0, 4'h0, 3'h0, 1'b0, 1'b0, 0, 1'b0, 0, '0, "R8");

    // R11: write and read the same record in one cycle
    setsel(5);
    cyc(1'b1, 4'hF, 3'h0, 4'h5, 4'h4, 3'h4, 1'b1, 1'b0, 0, 1'b1, 5, 64'hFACE_5A5A_0000_1111, "R11");
    rd(1'b1, "R11");

    @(negedge clk);
    acc_req = 1'b0; sel_we = 1'b0; rec_we = 1'b0; acc_allow = 1'b0;
    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL R1 scoreboard: actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule